// File: doc/BRIEF.md
# Per-Processor Counter-Timer Bank with User-Timer Mode

This block holds one counter-timer for each processor, up to sixteen of them, and a system-level mode register with one bit per processor. When a processor's mode bit is clear, its timer is an interrupting limit counter. The counter advances one period per tick, wraps at a programmable limit, raises a reached flag and drives that processor's interrupt line. When the mode bit is set, the same timer becomes a 64-bit user counter that software can start and stop. This counter is loaded and read in two 32-bit halves, and its interrupt line never asserts.

All register windows share one word-addressed bus. The `win_sys` input selects the system window, which holds the mode register. When `win_sys` is low, `bus_cpu` selects one processor's window. Reads are registered: `bus_rdata` updates on the clock edge that samples `bus_rd`. An external `tick` strobe marks each counting period. One period is bit 9 of the 64-bit user count and also bit 9 of the 32-bit counter view. Bits 8:0 always read as zero.

Top module: `cpu_timer_bank`

## Requirements
- R1: After reset every mode bit is 0, every processor timer is in counter mode with its running flag at 1, its limit and count are 0, and every interrupt output is low.
- R2: The mode mask is read and written at word 4 of the system window. Bits at or above NPROC are ignored and read 0. A write acts only on the bits that change. A write to word 4 of a processor window has no effect.
- R3: A mode bit changing from 0 to 1 lowers that processor's interrupt and clears its running flag, so the user timer starts out stopped.
- R4: A mode bit changing from 1 to 0 sets the running flag and clears that timer's count and limit. The limit value 0 means free-run at 0x7FFFFE00.
- R5: In user mode, word 0 reads {reached, count[62:32]} and word 1 reads count[31:0], with bits 8:0 zero. Reading either word clears nothing.
- R6: In user mode, writing word 0 loads count[62:32] from data bits 30:0, and writing word 1 loads count[31:9] from data bits 31:9. Either write clears the reached flag.
- R7: In user mode, writing word 3 with bit 0 set starts the timer and writing it with bit 0 clear stops it. Reading word 3 returns the running flag in bit 0. In counter mode, writes to word 3 are ignored.
- R8: A running user timer adds one period (2^9) per tick, with the carry passing from the low word into the high word. A stopped user timer holds its count.
- R9: A user timer that reaches 0x7FFFFFFFFFFFFE00 sets the reached flag and restarts from 0. Its interrupt output stays low at all times in user mode.
- R10: In counter mode, writing word 0 sets the limit from data bits 30:9, clears the count and lowers the interrupt. Writing word 2 sets the limit without touching the count, and writes to word 1 are ignored. When the count reaches the limit, the count restarts at 0, the reached flag sets and the interrupt rises. Word 1 reads {reached, count, 9'b0}. Reading word 0 returns the limit and clears both the reached flag and the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe marking one counting period |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data appears on `bus_rdata` after the same edge |
| win_sys | input | 1 | 1 selects the system window, 0 selects a processor window |
| bus_cpu | input | CPU_W | Processor index for processor windows |
| bus_word | input | 3 | Word index within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | NPROC | Interrupt level, one per processor |

## Verification
The assertions assume that a strobe and its address stay fixed for the single cycle the strobe is high. They also assume that `bus_wr` and `bus_rd` are never high together, and that a mode write never coincides with a processor-window write, since `win_sys` makes these exclusive. The stimulus drives every bus operation as one isolated cycle between falling edges, with `tick` held low. Ticks are issued as separate one-cycle pulses between bus operations, so a counting event never overlaps a load, a start or a mode change. The priorities among those collisions therefore go unexercised rather than being relied on.

// File: rtl/cpu_timer_pkg.sv
package cpu_timer_pkg;
  // count layout: 31 high bits + 23 low bits = 54 period bits (bit 9 upward)
  localparam int TICK_SHIFT = 9;
  localparam int HI_W       = 31;
  localparam int LO_KEEP    = 32 - TICK_SHIFT;
  localparam int PER_W      = HI_W + LO_KEEP;
  localparam int LIM_W      = 31 - TICK_SHIFT;

  localparam logic [2:0] W_HI_LIM    = 3'd0;
  localparam logic [2:0] W_LO_CNT    = 3'd1;
  localparam logic [2:0] W_LIM_NORST = 3'd2;
  localparam logic [2:0] W_STATUS    = 3'd3;
  localparam logic [2:0] W_MODE      = 3'd4;

  localparam logic [PER_W-1:0] USER_TOP = {PER_W{1'b1}};
  localparam logic [LIM_W-1:0] FREE_TOP = {LIM_W{1'b1}};

  function automatic logic [PER_W-1:0] ctr_top(input logic [LIM_W-1:0] lim);
    return (lim == '0) ? PER_W'(FREE_TOP) : PER_W'(lim);
  endfunction

  function automatic logic [31:0] user_hi_view(input logic reached,
                                               input logic [PER_W-1:0] cnt);
    return {reached, cnt[PER_W-1:LO_KEEP]};
  endfunction

  function automatic logic [31:0] user_lo_view(input logic [PER_W-1:0] cnt);
    return {cnt[LO_KEEP-1:0], {TICK_SHIFT{1'b0}}};
  endfunction

  function automatic logic [31:0] ctr_cnt_view(input logic reached,
                                               input logic [PER_W-1:0] cnt);
    return {reached, cnt[LIM_W-1:0], {TICK_SHIFT{1'b0}}};
  endfunction

  function automatic logic [31:0] ctr_lim_view(input logic [LIM_W-1:0] lim);
    return {1'b0, lim, {TICK_SHIFT{1'b0}}};
  endfunction
endpackage

// File: rtl/cpu_timer_mode.sv
module cpu_timer_mode #(
  parameter int NSLOT = 16,
  parameter int NPROC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [NSLOT-1:0] wdata,
  output logic [NSLOT-1:0] mode_q,
  output logic [NSLOT-1:0] go_user,
  output logic [NSLOT-1:0] go_ctr
);
  localparam logic [NSLOT-1:0] VALID = {NSLOT{1'b1}} >> (NSLOT - NPROC);

  logic [NSLOT-1:0] next_mask;
  logic [NSLOT-1:0] flip;

  always_comb begin
    next_mask = wdata & VALID;
    flip      = wr ? (next_mask ^ mode_q) : '0;
    go_user   = flip & next_mask;
    go_ctr    = flip & ~next_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= '0;
    else if (wr) mode_q <= next_mask;
  end

  // R2
  spare_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q & ~VALID) == '0);
  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(mode_q));
  // R2
  change_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_user & mode_q) == '0 && (go_ctr & ~mode_q) == '0);
endmodule

// File: rtl/cpu_timer_unit.sv
module cpu_timer_unit
  import cpu_timer_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        user_mode,
  input  logic        go_user,
  input  logic        go_ctr,
  input  logic        wr,
  input  logic        rd,
  input  logic [2:0]  word,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);
  logic [PER_W-1:0] cnt;
  logic [LIM_W-1:0] lim;
  logic             reached;
  logic             run;
  logic             irq_q;

  logic [PER_W:0]   cnt_inc;
  logic [PER_W-1:0] wrap_at;
  logic             wrap_evt;
  logic             rd_clr;
  logic             user_load;

  always_comb begin
    cnt_inc   = {1'b0, cnt} + (PER_W+1)'(1);
    wrap_at   = user_mode ? USER_TOP : ctr_top(lim);
    wrap_evt  = tick && run && !go_user && !go_ctr && (cnt_inc >= {1'b0, wrap_at});
    rd_clr    = rd && !user_mode && (word == W_HI_LIM);
    user_load = wr && user_mode && (word == W_HI_LIM || word == W_LO_CNT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      lim     <= '0;
      reached <= 1'b0;
      run     <= 1'b1;
      irq_q   <= 1'b0;
    end else if (go_user) begin
      irq_q <= 1'b0;
      run   <= 1'b0;
    end else if (go_ctr) begin
      run     <= 1'b1;
      cnt     <= '0;
      lim     <= '0;
      reached <= 1'b0;
    end else begin
      if (rd_clr) begin
        reached <= 1'b0;
        irq_q   <= 1'b0;
      end
      if (tick && run) begin
        if (wrap_evt) begin
          cnt     <= '0;
          reached <= 1'b1;
          if (!user_mode) irq_q <= 1'b1;
        end else begin
          cnt <= cnt_inc[PER_W-1:0];
        end
      end
      if (wr) begin
        if (user_mode) begin
          case (word)
            W_HI_LIM: begin
              cnt     <= {wdata[HI_W-1:0], cnt[LO_KEEP-1:0]};
              reached <= 1'b0;
            end
            W_LO_CNT: begin
              cnt     <= {cnt[PER_W-1:LO_KEEP], wdata[31:TICK_SHIFT]};
              reached <= 1'b0;
            end
            W_LIM_NORST: lim <= wdata[TICK_SHIFT+LIM_W-1:TICK_SHIFT];
            W_STATUS:    run <= wdata[0];
            default: ;
          endcase
        end else begin
          case (word)
            W_HI_LIM: begin
              lim   <= wdata[TICK_SHIFT+LIM_W-1:TICK_SHIFT];
              cnt   <= '0;
              irq_q <= 1'b0;
            end
            W_LIM_NORST: lim <= wdata[TICK_SHIFT+LIM_W-1:TICK_SHIFT];
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (word)
      W_HI_LIM: rdata = user_mode ? user_hi_view(reached, cnt) : ctr_lim_view(lim);
      W_LO_CNT: rdata = user_mode ? user_lo_view(cnt) : ctr_cnt_view(reached, cnt);
      W_STATUS: rdata = {31'b0, run};
      default:  rdata = '0;
    endcase
  end

  assign irq = irq_q;

  // R9
  user_irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    user_mode |-> !irq_q);
  // R3
  enter_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_user |=> (!run && !irq_q));
  // R4
  leave_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_ctr |=> (run && cnt == '0 && lim == '0));
  // R7
  ctr_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !user_mode |-> run);
  // R10
  ctr_wrap_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && !user_mode && !wr) |=> irq_q);
  // R9
  wrap_reach_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && !wr) |=> reached);
  // R6
  load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    user_load |=> !reached);
  // R8
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (user_mode && !run && !wr && !go_ctr) |=> $stable(cnt));
endmodule

// File: rtl/cpu_timer_bank.sv
module cpu_timer_bank
  import cpu_timer_pkg::*;
#(
  parameter int NSLOT = 16,
  parameter int NPROC = 4,
  localparam int CPU_W = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic             win_sys,
  input  logic [CPU_W-1:0] bus_cpu,
  input  logic [2:0]       bus_word,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic [NPROC-1:0] irq
);
  logic [NSLOT-1:0] mode_q;
  logic [NSLOT-1:0] go_user;
  logic [NSLOT-1:0] go_ctr;
  logic             mode_wr;
  logic [31:0]      unit_rd [NPROC];
  logic [31:0]      rd_mux;

  assign mode_wr = bus_wr && win_sys && (bus_word == W_MODE);

  cpu_timer_mode #(.NSLOT(NSLOT), .NPROC(NPROC)) u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (mode_wr),
    .wdata   (bus_wdata[NSLOT-1:0]),
    .mode_q  (mode_q),
    .go_user (go_user),
    .go_ctr  (go_ctr)
  );

  for (genvar i = 0; i < NPROC; i++) begin : g_cpu
    logic hit;
    assign hit = !win_sys && (bus_cpu == CPU_W'(i));
    cpu_timer_unit u_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .user_mode (mode_q[i]),
      .go_user   (go_user[i]),
      .go_ctr    (go_ctr[i]),
      .wr        (bus_wr && hit),
      .rd        (bus_rd && hit),
      .word      (bus_word),
      .wdata     (bus_wdata),
      .rdata     (unit_rd[i]),
      .irq       (irq[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (win_sys) begin
      if (bus_word == W_MODE) rd_mux = 32'(mode_q);
    end else begin
      for (int i = 0; i < NPROC; i++)
        if (bus_cpu == CPU_W'(i)) rd_mux = unit_rd[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R1
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/cpu_timer_bank_tb.sv
module cpu_timer_bank_tb;
  localparam int NSLOT = 16;
  localparam int NPROC = 4;
  localparam int CPU_W = $clog2(NSLOT);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tick = 1'b0;
  logic             bus_wr = 1'b0;
  logic             bus_rd = 1'b0;
  logic             win_sys = 1'b0;
  logic [CPU_W-1:0] bus_cpu = '0;
  logic [2:0]       bus_word = '0;
  logic [31:0]      bus_wdata = '0;
  logic [31:0]      bus_rdata;
  logic [NPROC-1:0] irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  cpu_timer_bank #(.NSLOT(NSLOT), .NPROC(NPROC)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .win_sys(win_sys), .bus_cpu(bus_cpu), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // {req[77:74], op[73:72] (0 write, 1 read), sys[71], cpu[70:67], word[66:64], data[63:32], expect[31:0]}
  localparam int NV = 23;
  localparam logic [77:0] VEC [NV] = '{
    {4'd1,  2'd1, 1'b1, 4'd0, 3'd4, 32'h0,        32'h0},        // R1 mode mask 0
    {4'd1,  2'd1, 1'b0, 4'd0, 3'd3, 32'h0,        32'h1},        // R1 running
    {4'd2,  2'd0, 1'b1, 4'd0, 3'd4, 32'h31,       32'h0},
    {4'd2,  2'd1, 1'b1, 4'd0, 3'd4, 32'h0,        32'h1},        // R2 spare bits dropped
    {4'd3,  2'd1, 1'b0, 4'd0, 3'd3, 32'h0,        32'h0},        // R3 stopped
    {4'd6,  2'd0, 1'b0, 4'd0, 3'd0, 32'h80000012, 32'h0},
    {4'd6,  2'd0, 1'b0, 4'd0, 3'd1, 32'h00001FFF, 32'h0},
    {4'd6,  2'd1, 1'b0, 4'd0, 3'd0, 32'h0,        32'h12},       // R6 high half
    {4'd6,  2'd1, 1'b0, 4'd0, 3'd1, 32'h0,        32'h1E00},     // R6 low half
    {4'd10, 2'd0, 1'b0, 4'd1, 3'd1, 32'h12345600, 32'h0},
    {4'd10, 2'd1, 1'b0, 4'd1, 3'd1, 32'h0,        32'h0},        // R10 word 1 ignored
    {4'd2,  2'd0, 1'b0, 4'd1, 3'd4, 32'hF,        32'h0},
    {4'd2,  2'd1, 1'b1, 4'd0, 3'd4, 32'h0,        32'h1},        // R2 processor window word 4
    {4'd7,  2'd0, 1'b0, 4'd0, 3'd3, 32'h1,        32'h0},
    {4'd7,  2'd1, 1'b0, 4'd0, 3'd3, 32'h0,        32'h1},        // R7 started
    {4'd7,  2'd0, 1'b0, 4'd1, 3'd3, 32'h0,        32'h0},
    {4'd7,  2'd1, 1'b0, 4'd1, 3'd3, 32'h0,        32'h1},        // R7 counter ignores stop
    {4'd10, 2'd0, 1'b0, 4'd3, 3'd2, 32'h400,      32'h0},
    {4'd10, 2'd1, 1'b0, 4'd3, 3'd0, 32'h0,        32'h400},      // R10 limit via word 2
    {4'd4,  2'd0, 1'b1, 4'd0, 3'd4, 32'h0,        32'h0},
    {4'd4,  2'd1, 1'b0, 4'd0, 3'd3, 32'h0,        32'h1},        // R4 running
    {4'd4,  2'd1, 1'b0, 4'd0, 3'd1, 32'h0,        32'h0},        // R4 count cleared
    {4'd4,  2'd1, 1'b0, 4'd0, 3'd0, 32'h0,        32'h0}         // R4 limit cleared
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic sys, input int cpu, input logic [2:0] w,
                           input logic [31:0] d);
    @(negedge clk);
    win_sys = sys; bus_cpu = CPU_W'(cpu); bus_word = w; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic sys, input int cpu, input logic [2:0] w,
                          output logic [31:0] d);
    @(negedge clk);
    win_sys = sys; bus_cpu = CPU_W'(cpu); bus_word = w; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic read_check(input int req, input int cpu, input logic [2:0] w,
                            input logic [31:0] exp);
    logic [31:0] d;
    bus_read(1'b0, cpu, w, d);
    check(req, d, exp);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(1, 32'(irq), 32'h0);  // R1 interrupts low

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][73:72] == 2'd0)
        bus_write(VEC[v][71], int'(VEC[v][70:67]), VEC[v][66:64], VEC[v][63:32]);
      else begin
        bus_read(VEC[v][71], int'(VEC[v][70:67]), VEC[v][66:64], d);
        check(int'(VEC[v][77:74]), d, VEC[v][31:0]);
      end
    end

    // R10 limit counter wrap and interrupt
    bus_write(1'b0, 1, 3'd0, 32'h0000_0C00);
    ticks(5);
    check(10, 32'(irq[1]), 32'h0);
    ticks(1);
    check(10, 32'(irq[1]), 32'h1);
    read_check(10, 1, 3'd1, 32'h8000_0000);
    read_check(10, 1, 3'd0, 32'h0000_0C00);
    check(10, 32'(irq[1]), 32'h0);
    read_check(10, 1, 3'd1, 32'h0);

    // R9 user timer reaching the top: reached flag, no interrupt
    bus_write(1'b1, 0, 3'd4, 32'h4);
    bus_write(1'b0, 2, 3'd0, 32'h7FFF_FFFF);
    bus_write(1'b0, 2, 3'd1, 32'hFFFF_FC00);
    read_check(5, 2, 3'd0, 32'h7FFF_FFFF);
    read_check(5, 2, 3'd1, 32'hFFFF_FC00);
    bus_write(1'b0, 2, 3'd3, 32'h1);
    ticks(1);
    check(9, 32'(irq[2]), 32'h0);
    read_check(9, 2, 3'd0, 32'h8000_0000);
    read_check(9, 2, 3'd1, 32'h0);
    read_check(5, 2, 3'd0, 32'h8000_0000);   // R5 read leaves reached set
    bus_write(1'b0, 2, 3'd1, 32'h0000_0200);
    read_check(6, 2, 3'd0, 32'h0);           // R6 load clears reached

    // R8 counting, holding while stopped, carry into high word
    ticks(3);
    read_check(8, 2, 3'd1, 32'h0000_0800);
    bus_write(1'b0, 2, 3'd3, 32'h0);
    ticks(2);
    read_check(8, 2, 3'd1, 32'h0000_0800);
    read_check(7, 2, 3'd3, 32'h0);
    bus_write(1'b0, 2, 3'd0, 32'h0);
    bus_write(1'b0, 2, 3'd1, 32'hFFFF_FE00);
    bus_write(1'b0, 2, 3'd3, 32'h1);
    ticks(1);
    read_check(8, 2, 3'd0, 32'h1);
    read_check(8, 2, 3'd1, 32'h0);

    // R3 entering user mode lowers a raised interrupt; R2 unchanged bit untouched
    bus_write(1'b0, 1, 3'd0, 32'h0000_0C00);
    ticks(6);
    check(10, 32'(irq[1]), 32'h1);
    bus_write(1'b1, 0, 3'd4, 32'h6);
    check(3, 32'(irq[1]), 32'h0);
    read_check(3, 1, 3'd3, 32'h0);
    read_check(2, 2, 3'd3, 32'h1);

    finish_run();
  end
endmodule